// File: doc/BRIEF.md
# Byte-Lane Static RAM Core

This block is a clocked, synthesizable model of a 16-bit asynchronous static RAM. It takes the control pins such a memory has: a word address, two chip selects of opposite polarity, an active-low write strobe, an active-low output enable, and one active-low enable for each byte. On every rising clock edge it samples these pins and works out which of four modes applies: standby, selected but quiet, read, or write. The two byte lanes are then handled separately. Each lane of the word is written or read only when its own enable is low.

Tri-state data pins are replaced by a 16-bit read bus and a two-bit lane-drive vector. A lane whose drive bit is low would be floating on a real pin, and here it shows zero on the read bus. Read data and drive bits are registered, so the result of a read appears one clock after the edge that sampled it. A write takes effect at the sampling edge, so a read in the next cycle returns the new data. The full-size organisation is 256K words with `ADDR_W` = 18. The default is 10 address bits, so that the array stays small in simulation.

Top module: `bytelane_sram`

## Requirements
- R1: While `rst` is high at a rising edge, `lane_drv` becomes 2'b00 and `rdata` becomes 16'h0000 after that edge. Memory contents are not cleared.
- R2: When `cs_n` is high or `cs_hi` is low, the device is in standby. No lane drives in the next cycle and no word is written, whatever the other pins do.
- R3: When the device is selected and both `lb_n` and `ub_n` are high, no lane drives in the next cycle and no word is written, even with `we_n` low.
- R4: A read is selected when `cs_n`=0, `cs_hi`=1, `we_n`=1, `oe_n`=0 and at least one byte enable is low. In the cycle after the sampling edge, `lane_drv` = {~ub_n, ~lb_n} as sampled, and each driven lane of `rdata` holds the stored byte of that address.
- R5: A write is selected when `cs_n`=0, `cs_hi`=1, `we_n`=0 and at least one byte enable is low. Only the lanes whose enable is low are stored, and the other byte of the word keeps its old value.
- R6: `lb_n` and `lane_drv[0]` belong to data bits 7:0. `ub_n` and `lane_drv[1]` belong to bits 15:8. Any lane with `lane_drv` bit 0 reads as 8'h00 on `rdata`.
- R7: `we_n` low forces `lane_drv` to 2'b00 in the next cycle, even when `oe_n` is low.
- R8: With the device selected, `we_n`=1 and `oe_n`=1, no lane drives in the next cycle and no word changes.
- R9: A word written at one edge is returned by a read sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Enable for bits 7:0, active low |
| ub_n | input | 1 | Enable for bits 15:8, active low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data; undriven lanes are zero |
| lane_drv | output | 2 | Registered per-lane drive flags (bit 0 = low byte) |

## Verification
The bench fills a 16-word configuration and then reads it back under each byte-enable combination. A design that swapped the lanes would return the wrong byte or set the wrong drive bit. Single-byte writes interleave with full-word writes. A design that wrote a whole word when only one lane was enabled would lose the neighbouring byte. Write attempts are also made in standby, with both byte enables high, and with the output enable high. The words are then read back, so a decoder that let any of these modes through would show altered contents. Last, the bench checks that a low write strobe silences the outputs while the output enable is low, and it reads each word in the cycle right after it is written. A read path that lagged by one cycle would return stale data.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_QUIET   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } mode_e;
endpackage

// File: rtl/bls_mode_dec.sv
module bls_mode_dec
  import bls_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [NLANE-1:0] be_n,
  output mode_e            mode,
  output logic [NLANE-1:0] lane_wr,
  output logic [NLANE-1:0] lane_rd
);
  // priority: select, then byte enables, then write strobe, then output enable
  always_comb begin
    if (cs_n || !cs_hi)     mode = MODE_STANDBY;
    else if (&be_n)         mode = MODE_QUIET;
    else if (!we_n)         mode = MODE_WRITE;
    else if (!oe_n)         mode = MODE_READ;
    else                    mode = MODE_QUIET;
  end

  always_comb begin
    lane_wr = '0;
    lane_rd = '0;
    if (mode == MODE_WRITE) lane_wr = ~be_n;
    if (mode == MODE_READ)  lane_rd = ~be_n;
  end
endmodule

// File: rtl/bls_lane_ram.sv
module bls_lane_ram #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // single-port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/bls_out_stage.sv
module bls_out_stage #(
  parameter int NLANE = 2,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NLANE-1:0]   lane_rd,
  input  logic [NLANE*W-1:0] ram_q,
  output logic [NLANE*W-1:0] rdata,
  output logic [NLANE-1:0]   lane_drv
);
  always_ff @(posedge clk) begin
    if (rst) lane_drv <= '0;
    else     lane_drv <= lane_rd;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_mask
    assign rdata[g*W +: W] = lane_drv[g] ? ram_q[g*W +: W] : '0;
  end
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        lane_drv
);
  mode_e              mode;
  logic [LANES-1:0]   lane_wr;
  logic [LANES-1:0]   lane_rd;
  logic [WORD_W-1:0]  ram_q;

  bls_mode_dec #(.NLANE(LANES)) i_dec (
    .cs_n    (cs_n),
    .cs_hi   (cs_hi),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .be_n    ({ub_n, lb_n}),
    .mode    (mode),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bls_lane_ram #(.AW(ADDR_W), .W(LANE_W)) i_ram (
      .clk   (clk),
      .wr_en (lane_wr[g]),
      .addr  (addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .q     (ram_q[g*LANE_W +: LANE_W])
    );
  end

  bls_out_stage #(.NLANE(LANES), .W(LANE_W)) i_out (
    .clk      (clk),
    .rst      (rst),
    .lane_rd  (lane_rd),
    .ram_q    (ram_q),
    .rdata    (rdata),
    .lane_drv (lane_drv)
  );
endmodule

// File: rtl/bytelane_sram_chk.sv
module bytelane_sram_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        cs_hi,
  input logic        we_n,
  input logic        oe_n,
  input logic        lb_n,
  input logic        ub_n,
  input logic [15:0] rdata,
  input logic [1:0]  lane_drv
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> lane_drv == 2'b00);
  // R2
  standby_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !cs_hi) |=> lane_drv == 2'b00);
  // R3
  no_lane_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs_hi && lb_n && ub_n) |=> lane_drv == 2'b00);
  // R4
  read_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && cs_hi && we_n && !oe_n) |=> lane_drv == ~{$past(ub_n), $past(lb_n)});
  // R7
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> lane_drv == 2'b00);
  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (we_n && oe_n) |=> lane_drv == 2'b00);
  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_drv == 2'b00) |-> rdata == 16'h0000);
endmodule

bind bytelane_sram bytelane_sram_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .cs_hi    (cs_hi),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .lb_n     (lb_n),
  .ub_n     (ub_n),
  .rdata    (rdata),
  .lane_drv (lane_drv)
);

// File: tb/test_bytelane_sram.sv
module test_bytelane_sram;
  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int NW    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, cs_hi = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic          lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    lane_drv;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] model [NW];

  always #(CLK_P/2) clk = ~clk;

  bytelane_sram #(.ADDR_W(AW)) i_bytelane_sram (
    .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .cs_hi(cs_hi),
    .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .wdata(wdata), .rdata(rdata), .lane_drv(lane_drv)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply pins at a falling edge, let one rising edge sample them, return at the next falling edge
  task automatic step(input logic c_n, input logic c_hi, input logic w_n, input logic o_n,
                      input logic l_n, input logic u_n, input logic [AW-1:0] a,
                      input logic [15:0] d);
    cs_n = c_n; cs_hi = c_hi; we_n = w_n; oe_n = o_n;
    lb_n = l_n; ub_n = u_n; addr = a; wdata = d;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    return 16'((a * 16'h1357 + k * 16'h0F1D) ^ 16'hA5C3);
  endfunction

  task automatic rd_check(input string req, input int a, input logic l_n, input logic u_n);
    logic [1:0]  edrv;
    logic [15:0] edat;
    step(0, 1, 1, 0, l_n, u_n, AW'(a), 16'h0);
    edrv = {~u_n, ~l_n};
    edat = {edrv[1] ? model[a][15:8] : 8'h00, edrv[0] ? model[a][7:0] : 8'h00};
    chk({req, " drv"}, {14'h0, lane_drv}, {14'h0, edrv});
    chk({req, " data"}, rdata, edat);
  endtask

  initial begin
    @(negedge clk);
    step(1, 0, 1, 1, 1, 1, '0, '0);
    step(1, 0, 1, 1, 1, 1, '0, '0);
    // R1 reset state
    chk("R1 drv", {14'h0, lane_drv}, 16'h0);
    chk("R1 data", rdata, 16'h0);
    rst = 1'b0;

    // R5 full-word fill, R9 immediate read-back of each word
    for (int a = 0; a < NW; a++) begin
      model[a] = pat(a, 0);
      step(0, 1, 0, 1, 0, 0, AW'(a), model[a]);
      rd_check("R9 back-to-back", a, 0, 0);
    end

    // R4/R6 read every word under each byte-enable combination
    for (int a = 0; a < NW; a++) begin
      rd_check("R4 both lanes", a, 0, 0);
      rd_check("R6 low lane only", a, 0, 1);
      rd_check("R6 high lane only", a, 1, 0);
    end

    // R5 single-lane writes: low byte at even addresses, high byte at odd
    for (int a = 0; a < NW; a++) begin
      logic [15:0] d;
      d = pat(a, 7);
      if (a % 2 == 0) begin
        step(0, 1, 0, 0, 0, 1, AW'(a), d);
        model[a][7:0] = d[7:0];
      end else begin
        step(0, 1, 0, 0, 1, 0, AW'(a), d);
        model[a][15:8] = d[15:8];
      end
      // R7 write strobe low with oe_n low: outputs stay off
      chk("R7 write hiz", {14'h0, lane_drv}, 16'h0);
    end
    for (int a = 0; a < NW; a++) rd_check("R5 lane merge", a, 0, 0);

    // R2 standby: writes blocked under both deselect forms, no drive
    for (int a = 0; a < NW; a++) begin
      step(1, 1, 0, 0, 0, 0, AW'(a), 16'hFFFF);
      chk("R2 cs_n high drv", {14'h0, lane_drv}, 16'h0);
      step(0, 0, 0, 0, 0, 0, AW'(a), 16'hFFFF);
      chk("R2 cs_hi low drv", {14'h0, lane_drv}, 16'h0);
      step(1, 1, 1, 0, 0, 0, AW'(a), 16'h0);
      chk("R2 standby read drv", {14'h0, lane_drv}, 16'h0);
      chk("R2 standby read data", rdata, 16'h0);
    end
    // R3 both byte enables high: no write, no drive
    for (int a = 0; a < NW; a++) begin
      step(0, 1, 0, 0, 1, 1, AW'(a), 16'h0000);
      step(0, 1, 1, 0, 1, 1, AW'(a), 16'h0000);
      chk("R3 no lane drv", {14'h0, lane_drv}, 16'h0);
    end
    // R8 output enable high: no drive and no change
    for (int a = 0; a < NW; a++) begin
      step(0, 1, 1, 1, 0, 0, AW'(a), 16'h5A5A);
      chk("R8 oe off drv", {14'h0, lane_drv}, 16'h0);
      chk("R8 oe off data", rdata, 16'h0);
    end
    for (int a = 0; a < NW; a++) rd_check("R2 R3 R8 contents kept", a, 0, 0);

    // R1 reset mid-run clears outputs after a read
    rd_check("R4 pre-reset", 3, 0, 0);
    rst = 1'b1;
    step(0, 1, 1, 0, 0, 0, AW'(3), 16'h0);
    chk("R1 mid-run drv", {14'h0, lane_drv}, 16'h0);
    rst = 1'b0;
    rd_check("R1 memory kept", 3, 0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule